// File: doc/BRIEF.md
# Multiplexed Pixel Word Assembler

This block rebuilds whole pixels from a narrow pixel bus that carries each pixel as a group of two or three words. In group-of-two mode a pixel takes two consecutive words (a then b); in group-of-three mode it takes three (a, b, then c). The bus may be sampled once per clock, or on both clock edges. Both-edge capture is modelled as a beat of two words per internal clock: the low lane is the word taken on the rising edge, the high lane the word taken on the falling edge.

Incoming beats arrive on a valid/ready stream with a start-of-line flag. The flag resets word alignment so that the first word of the flagged beat is word a. The flag is also the only point where the grouping mode and the capture mode are taken from their configuration pins. Finished pixels leave on a valid/ready stream with a chroma phase tag. The tag starts at Cb for the first pixel of each line and alternates Cb, Cr, Cb for 4:2:2 YCrCb input; for RGB input the tag can be ignored.

Flow control works as follows. A pixel on the output stays valid and unchanged until it is taken with `m_ready`. While such a pixel is waiting, `s_ready` is low and no input beat is consumed. While `s_valid` is low, input data and flags have no effect.

Top module: `pix_mux_assembler`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. Until the first start-of-line beat the block assembles in group-of-two, single-edge mode, whatever the configuration pins show.
- R2: In group-of-two mode every two accepted words a, b form one pixel `m_pixel = {zero word, b, a}`, with word a in the lowest `WORD_W` bits. `m_valid` rises in the cycle after the clock edge that accepts word b.
- R3: In group-of-three mode every three accepted words a, b, c form one pixel `m_pixel = {c, b, a}`. It is presented in the cycle after the edge that accepts word c.
- R4: In both-edge mode each accepted beat supplies two words: first `s_data[WORD_W-1:0]` (rising edge), then `s_data[2*WORD_W-1:WORD_W]` (falling edge). In single-edge mode only the low lane is used.
- R5: On an accepted beat with `s_sol` = 1, the first word of the beat is word a of a new pixel, and any partly gathered words are dropped. In single-edge mode such a beat therefore never produces a pixel.
- R6: `cfg_triplet` (1 = group of three) and `cfg_dual` (1 = both edges) are sampled only on accepted start-of-line beats. They apply from that beat on, and changes between such beats have no effect.
- R7: `m_cr` is 0 (Cb) for the first pixel after a start-of-line beat, or after reset. It inverts on each following pixel of the line.
- R8: While `m_valid` = 1 and `m_ready` = 0, `s_ready` is 0 and `m_valid`, `m_pixel` and `m_cr` hold their values at the next clock.
- R9: Cycles with `s_valid` = 0 consume no word, whatever `s_data`, `s_sol` and the configuration pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_triplet | input | 1 | Group size: 0 = two words, 1 = three words (sampled at line start) |
| cfg_dual | input | 1 | Capture: 0 = one word per beat, 1 = two words per beat (sampled at line start) |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with `s_valid` |
| s_sol | input | 1 | Start of line: realigns word a and restarts the chroma phase |
| s_data | input | 2*WORD_W | Low lane = rising-edge word, high lane = falling-edge word |
| m_valid | output | 1 | Assembled pixel valid |
| m_ready | input | 1 | Downstream takes the pixel |
| m_pixel | output | 3*WORD_W | Assembled pixel {c, b, a} |
| m_cr | output | 1 | Chroma phase: 0 = Cb, 1 = Cr |

## Verification
A pixel is due on `m_valid` exactly one clock after the edge that accepts the beat holding its last word; no other register lies on that path. The bench drives inputs at the falling edge and samples one time unit later. For every beat it sees accepted that closes a group, it expects `m_valid` high at the next sample point. A pixel held under back-pressure is expected unchanged at the following sample. Expected pixels and tags come from word indices within each line, and they are matched in order as they are taken by `m_ready`.

// File: rtl/pma_pkg.sv
package pma_pkg;
  typedef enum logic {
    GRP_PAIR    = 1'b0,
    GRP_TRIPLET = 1'b1
  } grp_mode_e;

  localparam int unsigned MAX_WORDS = 3;
  localparam int unsigned LANES     = 2;
  localparam int unsigned CNT_W     = $clog2(MAX_WORDS);

  function automatic logic [CNT_W-1:0] last_index(grp_mode_e m);
    return (m == GRP_TRIPLET) ? CNT_W'(2) : CNT_W'(1);
  endfunction
endpackage

// File: rtl/pma_word_slot.sv
module pma_word_slot
  import pma_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PIX_W = MAX_WORDS * WORD_W
) (
  input  logic              en,
  input  logic              restart,
  input  grp_mode_e         mode,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PIX_W-1:0]  slots_i,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PIX_W-1:0]  slots_o,
  output logic              done,
  output logic [PIX_W-1:0]  pix
);
  logic [CNT_W-1:0] idx;

  always_comb begin
    idx     = restart ? '0 : cnt_i;
    slots_o = slots_i;
    cnt_o   = cnt_i;
    done    = 1'b0;
    if (en) begin
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (idx == CNT_W'(k)) slots_o[k*WORD_W +: WORD_W] = word;
      end
      done  = (idx == last_index(mode));
      cnt_o = done ? '0 : idx + CNT_W'(1);
    end
    pix = slots_o;
    if (mode == GRP_PAIR) pix[(MAX_WORDS-1)*WORD_W +: WORD_W] = '0;
  end
endmodule

// File: rtl/pma_out_stage.sv
module pma_out_stage #(
  parameter int unsigned PIX_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             tag_in,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [PIX_W-1:0] m_pixel,
  output logic             m_cr,
  output logic             space
);
  assign space = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_pixel <= '0;
      m_cr    <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_pixel <= pix_in;
      m_cr    <= tag_in;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_mux_assembler.sv
module pix_mux_assembler
  import pma_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PIX_W = MAX_WORDS * WORD_W,
  localparam int unsigned BUS_W = LANES * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_triplet,
  input  logic             cfg_dual,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sol,
  input  logic [BUS_W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_pixel,
  output logic             m_cr
);
  grp_mode_e        mode_q, mode_eff;
  logic             dual_q, dual_eff;
  logic [CNT_W-1:0] cnt_q;
  logic [PIX_W-1:0] slots_q;
  logic             cr_q;
  logic             fire, space;

  logic [CNT_W-1:0] cnt_c   [LANES+1];
  logic [PIX_W-1:0] slots_c [LANES+1];
  logic             done_v  [LANES];
  logic [PIX_W-1:0] pix_v   [LANES];

  logic             done_any;
  logic [PIX_W-1:0] pix_sel;
  logic             tag_base;

  assign s_ready  = space;
  assign fire     = s_valid && space;
  assign mode_eff = s_sol ? grp_mode_e'(cfg_triplet) : mode_q;
  assign dual_eff = s_sol ? cfg_dual : dual_q;
  assign tag_base = s_sol ? 1'b0 : cr_q;

  assign cnt_c[0]   = cnt_q;
  assign slots_c[0] = slots_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = fire && ((g == 0) || dual_eff);
    pma_word_slot #(.WORD_W(WORD_W)) u_slot (
      .en      (lane_en),
      .restart (s_sol && (g == 0)),
      .mode    (mode_eff),
      .cnt_i   (cnt_c[g]),
      .slots_i (slots_c[g]),
      .word    (s_data[g*WORD_W +: WORD_W]),
      .cnt_o   (cnt_c[g+1]),
      .slots_o (slots_c[g+1]),
      .done    (done_v[g]),
      .pix     (pix_v[g])
    );
  end

  always_comb begin
    done_any = 1'b0;
    pix_sel  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (done_v[l]) begin
        done_any = 1'b1;
        pix_sel  = pix_v[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= GRP_PAIR;
      dual_q  <= 1'b0;
      cnt_q   <= '0;
      slots_q <= '0;
      cr_q    <= 1'b0;
    end else if (fire) begin
      cnt_q   <= cnt_c[LANES];
      slots_q <= slots_c[LANES];
      cr_q    <= done_any ? ~tag_base : tag_base;
      if (s_sol) begin
        mode_q <= mode_eff;
        dual_q <= cfg_dual;
      end
    end
  end

  pma_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fire && done_any),
    .pix_in  (pix_sel),
    .tag_in  (tag_base),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_pixel (m_pixel),
    .m_cr    (m_cr),
    .space   (space)
  );
endmodule

// File: rtl/pma_assembler_chk.sv
module pma_assembler_chk #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PIX_W = 3 * WORD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dual,
  input logic             s_valid,
  input logic             s_ready,
  input logic             s_sol,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_pixel,
  input logic             m_cr
);
  // R1: reset empties the output register
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !m_valid);

  // R8: a stalled pixel holds its value
  p_hold_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pixel) && $stable(m_cr)));

  // R8: no input accepted while the output is stalled
  p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R5: a single-lane line-start beat holds only word a
  p_sol_no_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_sol && !cfg_dual) |=> !m_valid);

  // R2: a fresh pixel needs an accepted beat in the cycle before
  p_pixel_from_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !$past(m_valid && !m_ready)) |-> $past(s_valid && s_ready));
endmodule

bind pix_mux_assembler pma_assembler_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_dual (cfg_dual),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_sol    (s_sol),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_pixel  (m_pixel),
  .m_cr     (m_cr)
);

// File: tb/pix_mux_assembler_test.sv
module pix_mux_assembler_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int QN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_triplet = 1'b0, cfg_dual = 1'b0;
  logic s_valid = 1'b0, s_sol = 1'b0, m_ready = 1'b0;
  logic [2*W-1:0] s_data = '0;
  logic s_ready, m_valid, m_cr;
  logic [3*W-1:0] m_pixel;

  pix_mux_assembler #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_triplet(cfg_triplet), .cfg_dual(cfg_dual),
    .s_valid(s_valid), .s_ready(s_ready), .s_sol(s_sol), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_pixel(m_pixel), .m_cr(m_cr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic finished = 1'b0;
  logic [3*W-1:0] exp_pix [QN];
  logic           exp_tag [QN];
  int head = 0, tail = 0;
  logic due_pix = 1'b0, hold_pend = 1'b0, hold_cr;
  logic [3*W-1:0] hold_pix;

  function automatic logic [W-1:0] wv(int line, int i);
    return W'(line * 29 + i * 7 + 3);
  endfunction

  task automatic sample_outputs();
    if (due_pix) begin
      checks++;
      if (!m_valid) begin errors++; $display("FAIL R2/R3 latency: m_valid=%0b expected 1", m_valid); end
      due_pix = 1'b0;
    end
    if (hold_pend) begin
      checks++;
      if (!m_valid || m_pixel !== hold_pix || m_cr !== hold_cr) begin
        errors++;
        $display("FAIL R8 hold: valid=%0b pix=%h cr=%0b expected 1 %h %0b", m_valid, m_pixel, m_cr, hold_pix, hold_cr);
      end
      hold_pend = 1'b0;
    end
    if (m_valid && !m_ready) begin
      checks++;
      if (s_ready) begin errors++; $display("FAIL R8 stall: s_ready=%0b expected 0", s_ready); end
      hold_pend = 1'b1; hold_pix = m_pixel; hold_cr = m_cr;
    end
    if (m_valid && m_ready) begin
      checks++;
      if (head == tail) begin
        errors++; $display("FAIL R2/R3 extra pixel: got %h expected none", m_pixel);
      end else begin
        if (m_pixel !== exp_pix[head] || m_cr !== exp_tag[head]) begin
          errors++;
          $display("FAIL R2/R3/R4/R5/R6/R7/R9 pixel: got %h tag %0b expected %h tag %0b",
                   m_pixel, m_cr, exp_pix[head], exp_tag[head]);
        end
        head = (head + 1) % QN;
      end
    end
  endtask

  task automatic step(input logic v, input logic sol, input logic [2*W-1:0] d,
                      input logic tr, input logic du, input logic rdy, output logic acc);
    @(negedge clk);
    s_valid = v; s_sol = sol; s_data = d;
    cfg_triplet = tr; cfg_dual = du; m_ready = rdy;
    #1;
    sample_outputs();
    acc = v && s_ready;
    cyc++;
  endtask

  // R9: idle gaps carry junk data, flags and config
  task automatic send_line(input logic trip, input logic du, input int beats,
                           input int line, input logic bp, input logic nosol);
    int lanes, n, widx;
    logic acc, rdy;
    lanes = du ? 2 : 1;
    n = trip ? 3 : 2;
    widx = 0;
    for (int b = 0; b < beats; b++) begin
      acc = 1'b0;
      while (!acc) begin
        rdy = bp ? ((cyc % 3) != 1) : 1'b1;
        if (((cyc + line) % 4) == 3)
          step(1'b0, 1'b1, ~{wv(line, widx + 1), wv(line, widx)}, ~trip, ~du, rdy, acc);
        else if (b == 0 && !nosol)
          step(1'b1, 1'b1, {wv(line, widx + 1), wv(line, widx)}, trip, du, rdy, acc);
        else // R6: config flipped away from the line's mode mid-line
          step(1'b1, 1'b0, {wv(line, widx + 1), wv(line, widx)}, ~trip, ~du, rdy, acc);
      end
      for (int l = 0; l < lanes; l++) begin
        int i;
        i = widx + l;
        if ((i % n) == n - 1) begin
          exp_pix[tail] = trip ? {wv(line, i), wv(line, i - 1), wv(line, i - 2)}
                               : {{W{1'b0}}, wv(line, i), wv(line, i - 1)};
          exp_tag[tail] = ((i / n) % 2) == 1; // R7
          tail = (tail + 1) % QN;
          due_pix = 1'b1;
        end
      end
      widx += lanes;
    end
  endtask

  initial begin
    logic acc;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      errors++; $display("FAIL R1 reset: m_valid=%0b s_ready=%0b expected 0 1", m_valid, s_ready);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: no line start yet, pins show triplet/dual but pair/single applies
    send_line(1'b0, 1'b0, 5, 99, 1'b0, 1'b1);
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 5; k++) begin
          int beats;
          beats = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 6 : (k == 3) ? 7 : 9;
          send_line(t[0], d[0], beats, t * 10 + d * 5 + k, k[0], 1'b0); // R3 R4 R5
        end
    repeat (6) step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, acc);
    checks++;
    if (head != tail) begin
      errors++; $display("FAIL R2/R3 missing pixels: outstanding %0d expected 0", (tail - head + QN) % QN);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule